// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Two-Level Overflow Status

This block multiplies two 32-bit operands and adds the product to, or subtracts it from, a 48-bit accumulator register. Each cycle that `in_valid` is high it performs one of four operations. It can accumulate, subtract-accumulate, form a plain product into a separate product register, or load the accumulator directly. Three mode inputs pick the arithmetic. The operands can be unsigned or signed integers, or signed fractions. For fractions, the product is aligned by one bit and then rounded or truncated before it is accumulated.

The unit keeps four status bits next to the accumulator. The zero flag reflects the last accumulator write. The overflow flag reports a product that did not fit or an accumulation that left the 48-bit range. The overflow flag also folds in a sticky per-accumulator overflow bit that only a load clears. The extension-overflow flag says the result has left its narrow home range: 32 bits for integers, 40 bits for fractions. When it is set, the 48-bit value is still exact, and a later operation that brings the value back into range clears the flag.

Top module: `mac_unit`

## Requirements
- R1: An operation is taken on a rising clock edge only when `in_valid` is high, and its results appear on the outputs right after that edge. While `in_valid` is low, every output holds its value. The `in_op` encoding is 0 for accumulate, 1 for subtract-accumulate, 2 for plain multiply and 3 for load.
- R2: Integer mode (`mode_frac`=0) treats the operands as signed when `mode_uns`=0 and as unsigned when `mode_uns`=1. The accumulator receives the low 48 bits of the exact 64-bit product. Op 0 sets the accumulator to accumulator plus product, and op 1 sets it to accumulator minus product.
- R3: Fractional mode (`mode_frac`=1) always treats the operands as signed. The exact product is shifted left one bit and then arithmetically shifted right by 24 bits. This places the binary point below bit 39 of the 48-bit value. With `mode_rnd`=1, 2^23 is added to the product before the shift, which rounds half up. With `mode_rnd`=0, the product is truncated.
- R4: A load (op 3) writes {`opnd_b[15:0]`, `opnd_a`} into the accumulator. It clears the overflow flag, the extension-overflow flag and the sticky bit.
- R5: A plain multiply (op 2) writes the product, formed as in R2/R3, into `prod_out`. It sets the overflow flag to that product's overflow alone. It leaves the accumulator, the zero flag, the extension-overflow flag and the sticky bit unchanged. No other operation changes `prod_out`.
- R6: After an op 0, 1 or 3, the zero flag is 1 exactly when the new accumulator is zero.
- R7: A product overflows under three conditions. In signed integer mode, the product is outside the signed 48-bit range. In unsigned integer mode, the product is at least 2^48. In fractional mode, both operands are 0x80000000.
- R8: An accumulation overflows under two conditions. In signed and fractional modes, the signed 48-bit sum or difference wraps. In unsigned mode, the addition carries out of bit 47 or the subtraction borrows.
- R9: After op 0 or 1, the overflow flag equals the OR of the product overflow, the accumulation overflow and the sticky bit held before the operation.
- R10: The sticky bit is set by any product or accumulation overflow during op 0 or 1. Only a load or reset clears it.
- R11: After op 0 or 1, the extension-overflow flag is set in three cases. In signed integer mode, the 48-bit result is outside the signed 32-bit range. In unsigned mode, the result is at least 2^32. In fractional mode, the result is outside the signed 40-bit range. Otherwise the flag is cleared.
- R12: While `rst` is high, the next clock edge sets both registers and all four status bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code (0 acc, 1 sub-acc, 2 multiply, 3 load) |
| mode_uns | input | 1 | Unsigned integer operands when high (ignored in fractional mode) |
| mode_frac | input | 1 | Fractional arithmetic |
| mode_rnd | input | 1 | Round fractional products instead of truncating |
| opnd_a | input | 32 | First operand / low load word |
| opnd_b | input | 32 | Second operand / load high half in bits 15:0 |
| acc_out | output | 48 | Accumulator |
| prod_out | output | 48 | Result of the last plain multiply |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_ev | output | 1 | Extension-overflow flag |
| acc_ovf_sticky | output | 1 | Sticky accumulator overflow bit |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. Idle cycles hold all state, and a plain multiply keeps the accumulator and the zero, extension and sticky bits. A load clears the overflow state and writes the concatenated operands. The sticky bit survives everything but a load, the overflow flag follows the sticky bit after each accumulate, and the zero flag matches the accumulator. Other behaviour needs chosen operand values and a reference model, so only the bench scenarios can show it. That covers the exact product arithmetic and the round-half-up against truncate choice, including negative fractions. It also covers the boundaries where a product or a sum overflows, the extension-overflow limit in each mode, and the flag clearing once the value returns to range.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPND_W     = 32;
    localparam int ACC_W      = 48;
    localparam int INT_FIT_W  = 32;
    localparam int FRAC_FIT_W = 40;
    localparam int FRAC_DROP  = 2 * OPND_W - FRAC_FIT_W;
    localparam int LOAD_HI_W  = ACC_W - OPND_W;
    localparam int PROD_W     = 2 * (OPND_W + 1);

    typedef enum logic [1:0] {
        OPC_MAC  = 2'd0,
        OPC_MSAC = 2'd1,
        OPC_MUL  = 2'd2,
        OPC_LOAD = 2'd3
    } mac_op_e;

    typedef struct packed {
        logic uns;
        logic frac;
        logic rnd;
    } mac_mode_t;

    typedef struct packed {
        logic [ACC_W-1:0] val;
        logic             ovf;
    } mac_prod_t;

    typedef struct packed {
        logic [ACC_W-1:0] val;
        logic             acc_ovf;
        logic             ext_ovf;
    } mac_sum_t;

    typedef struct packed {
        logic z;
        logic v;
        logic ev;
        logic sticky;
    } mac_flags_t;

    // value fits a signed field of width w when all bits from w-1 up match the sign
    function automatic logic fits_signed(input logic [ACC_W-1:0] v, input int w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < ACC_W; i++) begin
            if (i >= w - 1 && v[i] != v[ACC_W-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic fits_unsigned(input logic [ACC_W-1:0] v, input int w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < ACC_W; i++) begin
            if (i >= w && v[i]) ok = 1'b0;
        end
        return ok;
    endfunction

    // fractional arithmetic is always two's complement
    function automatic logic eff_unsigned(input mac_mode_t m);
        return m.uns & ~m.frac;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
(
    input  logic [OPND_W-1:0] a,
    input  logic [OPND_W-1:0] b,
    input  mac_mode_t         mode,
    output mac_prod_t         prod
);

    localparam int SH_W  = PROD_W + 1;
    localparam int KEEP_W = SH_W - FRAC_DROP;
    localparam logic [SH_W-1:0] HALF_LSB =
        {{KEEP_W{1'b0}}, 1'b1, {(FRAC_DROP-1){1'b0}}};
    localparam logic [OPND_W-1:0] MOST_NEG = {1'b1, {(OPND_W-1){1'b0}}};

    logic                     sgn;
    logic signed [OPND_W:0]   ea;
    logic signed [OPND_W:0]   eb;
    logic signed [PROD_W-1:0] full;
    logic signed [SH_W-1:0]   fr_sh;
    logic signed [SH_W-1:0]   fr_rnd;
    logic [FRAC_DROP-1:0]     unused_frac_lsbs;
    logic [ACC_W-1:0]         fr_val;
    logic                     ovf_s;
    logic                     ovf_u;
    logic                     ovf_f;

    always_comb begin
        sgn  = ~eff_unsigned(mode);
        ea   = {sgn & a[OPND_W-1], a};
        eb   = {sgn & b[OPND_W-1], b};
        full = ea * eb;

        // fraction path: align binary point, optional half-LSB bias, drop low bits
        fr_sh  = {full, 1'b0};
        fr_rnd = mode.rnd ? (fr_sh + $signed(HALF_LSB)) : fr_sh;
        unused_frac_lsbs = fr_rnd[FRAC_DROP-1:0];
        fr_val = {{(ACC_W-KEEP_W){fr_rnd[SH_W-1]}}, fr_rnd[SH_W-1:FRAC_DROP]};

        ovf_s = ~((&full[PROD_W-1:ACC_W-1]) | ~(|full[PROD_W-1:ACC_W-1]));
        ovf_u = |full[PROD_W-1:ACC_W];
        ovf_f = (a == MOST_NEG) && (b == MOST_NEG);

        if (mode.frac) begin
            prod.val = fr_val;
            prod.ovf = ovf_f;
        end else begin
            prod.val = full[ACC_W-1:0];
            prod.ovf = mode.uns ? ovf_u : ovf_s;
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] addend,
    input  logic             subtract,
    input  mac_mode_t        mode,
    output mac_sum_t         res
);

    logic           eu;
    logic [ACC_W:0] xa;
    logic [ACC_W:0] xp;
    logic [ACC_W:0] s;

    always_comb begin
        eu = eff_unsigned(mode);
        xa = {~eu & acc[ACC_W-1], acc};
        xp = {~eu & addend[ACC_W-1], addend};
        s  = subtract ? (xa - xp) : (xa + xp);

        res.val     = s[ACC_W-1:0];
        // unsigned: bit ACC_W is carry/borrow; signed: guard bit disagrees with sign
        res.acc_ovf = eu ? s[ACC_W] : (s[ACC_W] ^ s[ACC_W-1]);

        if (mode.frac)
            res.ext_ovf = ~fits_signed(s[ACC_W-1:0], FRAC_FIT_W);
        else if (eu)
            res.ext_ovf = ~fits_unsigned(s[ACC_W-1:0], INT_FIT_W);
        else
            res.ext_ovf = ~fits_signed(s[ACC_W-1:0], INT_FIT_W);
    end

endmodule

// File: rtl/mac_status.sv
module mac_status
    import mac_pkg::*;
(
    input  logic             fire,
    input  mac_op_e          op,
    input  mac_flags_t       cur,
    input  logic             prod_ovf,
    input  mac_sum_t         sum,
    input  logic [ACC_W-1:0] load_val,
    output mac_flags_t       nxt,
    output logic             acc_we,
    output logic             prod_we,
    output logic [ACC_W-1:0] acc_d
);

    always_comb begin
        nxt     = cur;
        acc_we  = 1'b0;
        prod_we = 1'b0;
        acc_d   = sum.val;
        if (fire) begin
            case (op)
                OPC_MAC, OPC_MSAC: begin
                    acc_we     = 1'b1;
                    nxt.z      = ~|sum.val;
                    nxt.v      = prod_ovf | sum.acc_ovf | cur.sticky;
                    nxt.sticky = prod_ovf | sum.acc_ovf | cur.sticky;
                    nxt.ev     = sum.ext_ovf;
                end
                OPC_MUL: begin
                    prod_we = 1'b1;
                    nxt.v   = prod_ovf;
                end
                OPC_LOAD: begin
                    acc_we     = 1'b1;
                    acc_d      = load_val;
                    nxt.z      = ~|load_val;
                    nxt.v      = 1'b0;
                    nxt.ev     = 1'b0;
                    nxt.sticky = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              mode_uns,
    input  logic              mode_frac,
    input  logic              mode_rnd,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic [ACC_W-1:0]  acc_out,
    output logic [ACC_W-1:0]  prod_out,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_ev,
    output logic              acc_ovf_sticky
);

    mac_mode_t        mode;
    mac_op_e          op;
    mac_prod_t        prod;
    mac_sum_t         sum;
    mac_flags_t       flags_q;
    mac_flags_t       flags_d;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] prod_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] load_val;
    logic             acc_we;
    logic             prod_we;

    assign mode     = '{uns: mode_uns, frac: mode_frac, rnd: mode_rnd};
    assign op       = mac_op_e'(in_op);
    assign load_val = {opnd_b[LOAD_HI_W-1:0], opnd_a};

    mac_mult u_mult (
        .a    (opnd_a),
        .b    (opnd_b),
        .mode (mode),
        .prod (prod)
    );

    mac_accum u_accum (
        .acc      (acc_q),
        .addend   (prod.val),
        .subtract (op == OPC_MSAC),
        .mode     (mode),
        .res      (sum)
    );

    mac_status u_status (
        .fire     (in_valid),
        .op       (op),
        .cur      (flags_q),
        .prod_ovf (prod.ovf),
        .sum      (sum),
        .load_val (load_val),
        .nxt      (flags_d),
        .acc_we   (acc_we),
        .prod_we  (prod_we),
        .acc_d    (acc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            prod_q  <= '0;
            flags_q <= '0;
        end else begin
            if (acc_we)  acc_q  <= acc_d;
            if (prod_we) prod_q <= prod.val;
            flags_q <= flags_d;
        end
    end

    assign acc_out        = acc_q;
    assign prod_out       = prod_q;
    assign flag_z         = flags_q.z;
    assign flag_v         = flags_q.v;
    assign flag_ev        = flags_q.ev;
    assign acc_ovf_sticky = flags_q.sticky;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
    import mac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [OPND_W-1:0] opnd_a,
    input logic [OPND_W-1:0] opnd_b,
    input logic [ACC_W-1:0]  acc_out,
    input logic [ACC_W-1:0]  prod_out,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_ev,
    input logic              acc_ovf_sticky
);

    logic is_acc_op;
    assign is_acc_op = in_valid && (in_op == OPC_MAC || in_op == OPC_MSAC);

    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && prod_out == '0 && !flag_z && !flag_v && !flag_ev && !acc_ovf_sticky));

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(acc_out) && $stable(prod_out) && $stable(flag_z) &&
                       $stable(flag_v) && $stable(flag_ev) && $stable(acc_ovf_sticky)));

    a_r5_mul_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OPC_MUL) |=> ($stable(acc_out) && $stable(flag_z) &&
                                            $stable(flag_ev) && $stable(acc_ovf_sticky)));

    a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OPC_LOAD) |=> (!flag_v && !flag_ev && !acc_ovf_sticky &&
            acc_out == {$past(opnd_b[LOAD_HI_W-1:0]), $past(opnd_a)}));

    a_r6_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != OPC_MUL) |=> (flag_z == (acc_out == '0)));

    a_r10_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (acc_ovf_sticky && !(in_valid && in_op == OPC_LOAD)) |=> acc_ovf_sticky);

    a_r9_v_from_sticky: assert property (@(posedge clk) disable iff (rst)
        (is_acc_op && acc_ovf_sticky) |=> flag_v);

    a_r10_v_matches_sticky: assert property (@(posedge clk) disable iff (rst)
        is_acc_op |=> (flag_v == acc_ovf_sticky));

endmodule

bind mac_unit mac_unit_chk u_chk (.*);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
    import mac_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic        mode_uns, mode_frac, mode_rnd;
    logic [31:0] opnd_a, opnd_b;
    logic [47:0] acc_out, prod_out;
    logic        flag_z, flag_v, flag_ev, acc_ovf_sticky;

    always #2 clk = ~clk;

    mac_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .mode_uns(mode_uns), .mode_frac(mode_frac), .mode_rnd(mode_rnd),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_out(acc_out), .prod_out(prod_out),
        .flag_z(flag_z), .flag_v(flag_v), .flag_ev(flag_ev), .acc_ovf_sticky(acc_ovf_sticky)
    );

    typedef struct {
        logic [47:0] acc;
        logic [47:0] prod;
        logic        z, v, ev, st;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    exp_item_t it;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] m_acc = '0, m_prod = '0;
    logic        m_z = 0, m_v = 0, m_ev = 0, m_st = 0;

    function automatic logic signed [129:0] ext130(input logic [47:0] v, input logic zext);
        return zext ? $signed({82'd0, v}) : $signed({{82{v[47]}}, v});
    endfunction

    task automatic push_exp(input string tag);
        exp_item_t e;
        e.acc = m_acc; e.prod = m_prod; e.z = m_z; e.v = m_v; e.ev = m_ev; e.st = m_st;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic u, input logic f, input logic r, input string tag);
        logic signed [129:0] pa, pb, full, s, ra;
        logic [47:0] p48;
        logic povf, aovf, eu;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; opnd_a = a; opnd_b = b;
        mode_uns = u; mode_frac = f; mode_rnd = r;
        eu = u & ~f;
        pa = eu ? $signed({98'd0, a}) : $signed({{98{a[31]}}, a});
        pb = eu ? $signed({98'd0, b}) : $signed({{98{b[31]}}, b});
        full = pa * pb;
        if (f) begin
            full = full * 2;
            if (r) full = full + 130'sd8388608;
            full = full >>> 24;
            povf = (a == 32'h8000_0000) && (b == 32'h8000_0000);
        end else if (eu) begin
            povf = full >= 130'sd281474976710656;
        end else begin
            povf = (full > 130'sd140737488355327) || (full < -130'sd140737488355328);
        end
        p48 = full[47:0];
        case (op)
            OPC_MUL: begin
                m_prod = p48;
                m_v = povf;
            end
            OPC_LOAD: begin
                m_acc = {b[15:0], a};
                m_z = (m_acc == 48'd0);
                m_v = 0; m_ev = 0; m_st = 0;
            end
            default: begin
                s = (op == OPC_MAC) ? ext130(m_acc, eu) + ext130(p48, eu)
                                    : ext130(m_acc, eu) - ext130(p48, eu);
                if (eu) aovf = (s >= 130'sd281474976710656) || (s < 0);
                else    aovf = (s > 130'sd140737488355327) || (s < -130'sd140737488355328);
                m_acc = s[47:0];
                m_z = (m_acc == 48'd0);
                m_v = povf | aovf | m_st;
                m_st = m_v;
                ra = ext130(m_acc, eu);
                if (f)       m_ev = (ra > 130'sd549755813887) || (ra < -130'sd549755813888);
                else if (eu) m_ev = (ra >= 130'sd4294967296);
                else         m_ev = (ra > 130'sd2147483647) || (ra < -130'sd2147483648);
            end
        endcase
        push_exp(tag);
    endtask

    // R1: operation inputs toggle while the strobe is low and must be ignored
    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; in_op = 2'($urandom_range(0, 3));
        opnd_a = $urandom; opnd_b = $urandom;
        push_exp(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (acc_out !== it.acc || prod_out !== it.prod || flag_z !== it.z ||
                flag_v !== it.v || flag_ev !== it.ev || acc_ovf_sticky !== it.st) begin
                errors++;
                $display("FAIL %s: acc=%h prod=%h z%b v%b ev%b st%b expected acc=%h prod=%h z%b v%b ev%b st%b",
                         it.tag, acc_out, prod_out, flag_z, flag_v, flag_ev, acc_ovf_sticky,
                         it.acc, it.prod, it.z, it.v, it.ev, it.st);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; opnd_a = '1; opnd_b = '1;
        mode_uns = 0; mode_frac = 0; mode_rnd = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (acc_out !== 48'd0 || prod_out !== 48'd0 || flag_z || flag_v || flag_ev || acc_ovf_sticky) begin
            errors++;
            $display("FAIL R12: acc=%h prod=%h flags=%b%b%b%b expected all zero",
                     acc_out, prod_out, flag_z, flag_v, flag_ev, acc_ovf_sticky);
        end

        // R4 / R2: signed integer accumulate and subtract
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R4");
        issue(OPC_MAC, 32'd3, 32'hFFFF_FFFB, 0, 0, 0, "R2");
        issue(OPC_MSAC, 32'hFFFF_FFFE, 32'hFFFF_FFF9, 0, 0, 0, "R2");
        idle("R1"); idle("R1");
        issue(OPC_LOAD, 32'h1234_5678, 32'h0000_ABCD, 0, 0, 0, "R4");
        // R6: zero flag
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R6");
        issue(OPC_MAC, 32'd0, 32'd5, 0, 0, 0, "R6");
        issue(OPC_MAC, 32'd1, 32'd1, 0, 0, 0, "R6");
        issue(OPC_MSAC, 32'd1, 32'd1, 0, 0, 0, "R6");
        // R11: extension overflow in unsigned mode, set and cleared
        issue(OPC_MAC, 32'hFFFF_FFFF, 32'd2, 1, 0, 0, "R11");
        issue(OPC_MSAC, 32'hFFFF_FFFF, 32'd2, 1, 0, 0, "R11");
        issue(OPC_MAC, 32'h0001_0000, 32'h0001_0000, 1, 0, 0, "R11");
        issue(OPC_MSAC, 32'd1, 32'd1, 1, 0, 0, "R11");
        // R11: signed integer boundary
        issue(OPC_LOAD, 32'h7FFF_FFFF, 32'd0, 0, 0, 0, "R11");
        issue(OPC_MAC, 32'd1, 32'd1, 0, 0, 0, "R11");
        issue(OPC_MSAC, 32'd1, 32'd1, 0, 0, 0, "R11");
        // R7 / R10 / R5 / R9: product overflow, sticky, plain multiply
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R10");
        issue(OPC_MAC, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, "R7");
        issue(OPC_MAC, 32'd1, 32'd1, 0, 0, 0, "R10");
        issue(OPC_MUL, 32'd2, 32'd3, 0, 0, 0, "R5");
        idle("R1");
        issue(OPC_MAC, 32'd1, 32'd1, 0, 0, 0, "R9");
        issue(OPC_LOAD, 32'd7, 32'd0, 0, 0, 0, "R10");
        issue(OPC_MUL, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, "R7");
        issue(OPC_MUL, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        // R8: accumulation overflow
        issue(OPC_LOAD, 32'hFFFF_FFFF, 32'h0000_7FFF, 0, 0, 0, "R8");
        issue(OPC_MAC, 32'd1, 32'd1, 0, 0, 0, "R8");
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R8");
        issue(OPC_MSAC, 32'd1, 32'd1, 1, 0, 0, "R8");
        issue(OPC_LOAD, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 0, "R8");
        issue(OPC_MAC, 32'd1, 32'd1, 1, 0, 0, "R8");
        // R3: fractional alignment, truncate and round
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R3");
        issue(OPC_MAC, 32'h0040_0000, 32'd1, 0, 1, 0, "R3");
        issue(OPC_MAC, 32'h0040_0000, 32'd1, 0, 1, 1, "R3");
        issue(OPC_MSAC, 32'hFFC0_0000, 32'd1, 0, 1, 0, "R3");
        issue(OPC_MSAC, 32'hFFC0_0000, 32'd1, 1, 1, 1, "R3");
        issue(OPC_MUL, 32'h4000_0000, 32'h4000_0000, 0, 1, 0, "R3");
        issue(OPC_MUL, 32'h0000_0003, 32'h0080_0000, 0, 1, 1, "R3");
        // R7 / R11: fractional product overflow and 40-bit range
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R7");
        issue(OPC_MAC, 32'h8000_0000, 32'h8000_0000, 0, 1, 0, "R7");
        issue(OPC_LOAD, 32'd0, 32'd0, 0, 0, 0, "R11");
        issue(OPC_MAC, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 1, "R11");
        issue(OPC_MAC, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 1, "R11");
        issue(OPC_MSAC, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 1, "R11");
        // mixed traffic against the model
        for (int i = 0; i < 80; i++) begin
            if (($urandom % 8) == 0) idle("R1");
            else issue(2'($urandom_range(0, 3)), $urandom, $urandom,
                       1'($urandom), 1'($urandom), 1'($urandom), "R2");
        end
        idle("R1");
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule